// File: doc/BRIEF.md
# Serial Flash Buffered Page Program Front End

This block is the device-side command logic of a serial flash. The host talks to it over an SPI mode-0 link: chip select is active low, SI is sampled on rising SCK, and SO changes on falling SCK. All three pins are brought into the system clock domain through synchronisers. A command starts with a one-byte opcode. For the program and rewrite commands a 24-bit address field follows it: two reserved bits, a 12-bit page number, then a 10-bit buffer byte address.

A program command streams data bytes into one of two page-sized SRAM buffers, starting at the given byte address and wrapping at the end of the buffer. When chip select rises, a self-timed internal sequence starts. It fills the target page with FFh, then copies the whole buffer into that page. A rewrite command first loads the page into a buffer and then programs it back. A status command reports ready or busy on SO.

The main array is a small behavioural model. It holds `ARR_PAGES` pages, and the page number taken modulo `ARR_PAGES` selects one of them. A combinational read port lets the array be inspected. `BUSY_CYCLES` sets the minimum busy time in system clock cycles.

Top module: `flash_buf_prog`

## Requirements
- R1: Opcode 82h writes data into buffer 1 and opcode 85h writes into buffer 2. Each data byte is 8 SI bits, MSB first, stored at the buffer pointer, which then advances by one.
- R2: The 24 address bits after the opcode are laid out as 2 reserved bits, then page[11:0], then byte[9:0], all MSB first. The starting byte address is taken modulo 528, so 600 maps to 72.
- R3: After buffer byte 527 the pointer wraps to byte 0.
- R4: A rising edge on chip select after a complete program header starts the internal sequence. When it finishes, the target page holds exactly the selected buffer's 528 bytes. A partial trailing byte is dropped.
- R5: Opcodes 58h (buffer 1) and 59h (buffer 2) copy the addressed page into the buffer and then program the buffer back into that page. Afterwards the page is unchanged and the buffer equals the page.
- R6: After opcode 57h, SO shifts out the status byte MSB first. Bit 7 is ready, bits 6:3 are 1011b and bits 2:0 are 000b, so the byte reads D8h when ready and 58h when busy. The byte repeats from bit 7 for as long as chip select stays low, and it is re-sampled at each repetition. SO is 0 while chip select is high.
- R7: Once started, the internal sequence holds the status busy for at least `BUSY_CYCLES` system clock cycles, and then returns to ready.
- R8: If chip select rises before all 32 header bits have arrived, no internal sequence starts and no byte changes.
- R9: While busy, any opcode other than 57h is ignored. Neither the buffers nor the array change.
- R10: After reset the status reads ready, and every byte of the array and both buffers is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (status) |
| arr_rd_page | input | 12 | Page number for the array inspection port (taken modulo ARR_PAGES) |
| arr_rd_byte | input | 10 | Byte index for the array inspection port |
| arr_rd_data | output | 8 | Array byte at the inspected location |

## Verification
On every cycle the assertions check the following:
- A commit happens only on a chip-select rise, and busy follows it immediately.
- Busy never ends before `BUSY_CYCLES`.
- The decoder issues no buffer write while busy, and its write address stays inside the buffer.
- SO holds still except on a falling SCK, and is 0 while deselected.

Other behaviours only the directed scenarios can show: the page contents after a program or a rewrite, the modulo mapping of the start address, the pointer wrap, the dropped aborted header, and the status byte values and their repetition across a busy-to-ready change.

// File: rtl/flash_cmd_pkg.sv
// Package: opcode values and the command classification shared by the
// decoder and the top level of the buffered page program front end.
package flash_cmd_pkg;
    localparam logic [7:0] OPC_PROG_B1 = 8'h82;
    localparam logic [7:0] OPC_PROG_B2 = 8'h85;
    localparam logic [7:0] OPC_REWR_B1 = 8'h58;
    localparam logic [7:0] OPC_REWR_B2 = 8'h59;
    localparam logic [7:0] OPC_STATUS  = 8'h57;

    localparam int HDR_BITS = 32;

    typedef enum logic [2:0] {
        K_NONE,
        K_PROG,
        K_REWR,
        K_STAT,
        K_IGN
    } cmd_kind_e;
endpackage

// File: rtl/spi_front.sv
// Module: spi_front
// Brings cs_n, sck and si into the system clock domain and reports SCK
// and chip-select edges as one-cycle pulses.
// Assumes: SCK half period is at least SYNC_STAGES+2 system clocks.
module spi_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sel,
    output logic si_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    localparam int         LANES    = 3;
    localparam logic [2:0] LANE_RST = 3'b100;   // {cs_n, sck, si}

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;
    logic             sck_d;
    logic             cs_d;

    assign raw = {cs_n, sck, si};

    for (genvar g = 0; g < LANES; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        // Shift each pin through its synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {SYNC_STAGES{LANE_RST[g]}};
            else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    // Keep the previous synced level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= synced[1];
            cs_d  <= synced[2];
        end
    end

    assign si_s     = synced[0];
    assign sel      = !synced[2];
    assign sck_rise = sel && synced[1] && !sck_d;
    assign sck_fall = sel && !synced[1] && sck_d;
    assign cs_fall  = cs_d && !synced[2];
    assign cs_rise  = !cs_d && synced[2];
endmodule

// File: rtl/cmd_decoder.sv
// Module: cmd_decoder
// Assembles opcode, header and data bytes from sampled SI bits. It issues
// buffer writes with a wrapping pointer and a commit request on a chip-select rise.
// Assumes: 512 < BUF_BYTES <= 1023, so one subtraction reduces the address.
module cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int BUF_BYTES = 528,
    parameter int PTR_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             si_s,
    input  logic             sck_rise,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             busy,
    output logic             wr_en,
    output logic             wr_sel,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             commit,
    output logic             commit_rewr,
    output logic [11:0]      commit_page,
    output logic             stat_mode
);
    localparam logic [PTR_W-1:0] LAST_BYTE = PTR_W'(BUF_BYTES - 1);
    localparam logic [9:0]       BUF_SIZE  = 10'(BUF_BYTES);

    logic [20:0]     shreg;
    logic [21:0]     w_now;
    logic [5:0]      bit_cnt;
    logic [2:0]      dbit;
    logic [PTR_W-1:0] ptr;
    cmd_kind_e       kind;
    logic [9:0]      ba_mod;

    assign w_now  = {shreg, si_s};
    assign ba_mod = (w_now[9:0] >= BUF_SIZE) ? (w_now[9:0] - BUF_SIZE) : w_now[9:0];
    assign stat_mode = (kind == K_STAT);

    // Track bit position, classify the opcode, capture header and stream data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            bit_cnt     <= '0;
            dbit        <= '0;
            ptr         <= '0;
            kind        <= K_NONE;
            wr_en       <= 1'b0;
            wr_sel      <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            commit      <= 1'b0;
            commit_rewr <= 1'b0;
            commit_page <= '0;
        end else begin
            wr_en  <= 1'b0;
            commit <= 1'b0;
            if (cs_fall) begin
                bit_cnt <= '0;
                dbit    <= '0;
                kind    <= K_NONE;
            end else if (sck_rise) begin
                shreg <= w_now[20:0];
                if (bit_cnt < 6'(HDR_BITS)) bit_cnt <= bit_cnt + 6'd1;
                if (bit_cnt == 6'd7) begin
                    if (w_now[7:0] == OPC_STATUS) kind <= K_STAT;
                    else if (busy) kind <= K_IGN;
                    else if (w_now[7:0] == OPC_PROG_B1 || w_now[7:0] == OPC_PROG_B2) begin
                        kind   <= K_PROG;
                        wr_sel <= w_now[2];
                    end else if (w_now[7:0] == OPC_REWR_B1 || w_now[7:0] == OPC_REWR_B2) begin
                        kind   <= K_REWR;
                        wr_sel <= w_now[0];
                    end else kind <= K_IGN;
                end
                if (bit_cnt == 6'(HDR_BITS - 1)) begin
                    commit_page <= w_now[21:10];
                    ptr         <= PTR_W'(ba_mod);
                end
                if (bit_cnt == 6'(HDR_BITS) && kind == K_PROG) begin
                    dbit <= dbit + 3'd1;
                    if (dbit == 3'd7) begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= w_now[7:0];
                        ptr     <= (ptr == LAST_BYTE) ? '0 : ptr + 1'b1;
                    end
                end
            end
            if (cs_rise && bit_cnt == 6'(HDR_BITS) && !busy &&
                (kind == K_PROG || kind == K_REWR)) begin
                commit      <= 1'b1;
                commit_rewr <= (kind == K_REWR);
            end
        end
    end
endmodule

// File: rtl/status_tx.sv
// Module: status_tx
// Shifts the status byte out on SO, MSB first, changing on falling SCK,
// and re-captures the status at the start of each 8-bit repetition.
// Assumes: stat_mode becomes true before the first falling SCK after the opcode.
module status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       cs_fall,
    input  logic       sck_fall,
    input  logic       stat_mode,
    input  logic [7:0] status,
    output logic       so
);
    logic [2:0] idx;
    logic [6:0] rest;

    // Drive SO from a fresh snapshot at bit 7, then from the shifted remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            rest <= '0;
            so   <= 1'b0;
        end else if (!sel || cs_fall) begin
            idx  <= '0;
            so   <= 1'b0;
        end else if (sck_fall && stat_mode) begin
            idx <= idx + 3'd1;
            if (idx == 3'd0) begin
                so   <= status[7];
                rest <= status[6:0];
            end else begin
                so   <= rest[6];
                rest <= {rest[5:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/page_engine.sv
// Module: page_engine
// Holds the two page buffers and the behavioural main array, and runs the
// self-timed load / erase / program sequence after a commit.
// Assumes: ARR_PAGES >= 2, BUSY_CYCLES >= 1; commits arrive only while idle.
module page_engine #(
    parameter int BUF_BYTES   = 528,
    parameter int ARR_PAGES   = 2,
    parameter int BUSY_CYCLES = 1500,
    parameter int PTR_W       = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic             commit_rewr,
    input  logic [11:0]      commit_page,
    input  logic [11:0]      rd_page,
    input  logic [PTR_W-1:0] rd_byte,
    output logic [7:0]       rd_data,
    output logic             busy
);
    localparam int               IDX_W     = $clog2(ARR_PAGES);
    localparam int               TMR_W     = $clog2(BUSY_CYCLES + 1);
    localparam logic [PTR_W-1:0] LAST_BYTE = PTR_W'(BUF_BYTES - 1);

    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ERASE, S_PROG, S_HOLD} eng_st_e;

    logic [7:0]       bufm [2][BUF_BYTES];
    logic [7:0]       arr  [ARR_PAGES][BUF_BYTES];
    eng_st_e          st;
    logic [PTR_W-1:0] idx;
    logic [TMR_W-1:0] tmr;
    logic [IDX_W-1:0] tgt;
    logic             bsel;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] cm_idx;

    assign rd_idx  = IDX_W'(rd_page % ARR_PAGES);
    assign cm_idx  = IDX_W'(commit_page % ARR_PAGES);
    assign rd_data = arr[rd_idx][rd_byte];
    assign busy    = (st != S_IDLE);

    // Sequencer plus the storage it and the decoder write into.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            idx  <= '0;
            tmr  <= '0;
            tgt  <= '0;
            bsel <= 1'b0;
            for (int b = 0; b < BUF_BYTES; b++) begin
                bufm[0][b] <= 8'h00;
                bufm[1][b] <= 8'h00;
                for (int p = 0; p < ARR_PAGES; p++) arr[p][b] <= 8'h00;
            end
        end else begin
            if (st != S_IDLE && tmr < TMR_W'(BUSY_CYCLES)) tmr <= tmr + 1'b1;
            case (st)
                S_IDLE: begin
                    if (wr_en) bufm[wr_sel][wr_addr] <= wr_data;
                    if (commit) begin
                        tgt  <= cm_idx;
                        bsel <= wr_sel;
                        idx  <= '0;
                        tmr  <= '0;
                        st   <= commit_rewr ? S_LOAD : S_ERASE;
                    end
                end
                S_LOAD: begin
                    bufm[bsel][idx] <= arr[tgt][idx];
                    idx <= (idx == LAST_BYTE) ? '0 : idx + 1'b1;
                    if (idx == LAST_BYTE) st <= S_ERASE;
                end
                S_ERASE: begin
                    arr[tgt][idx] <= 8'hFF;
                    idx <= (idx == LAST_BYTE) ? '0 : idx + 1'b1;
                    if (idx == LAST_BYTE) st <= S_PROG;
                end
                S_PROG: begin
                    arr[tgt][idx] <= bufm[bsel][idx];
                    idx <= (idx == LAST_BYTE) ? '0 : idx + 1'b1;
                    if (idx == LAST_BYTE) st <= S_HOLD;
                end
                S_HOLD: begin
                    if (tmr >= TMR_W'(BUSY_CYCLES - 1)) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_buf_prog.sv
// Module: flash_buf_prog (top)
// Serial flash command front end: SPI mode-0 pin interface, command
// decoder, status shifter and the buffer/array page engine.
// Assumes: all pins are asynchronous to clk and slow relative to it.
module flash_buf_prog #(
    parameter int         BUF_BYTES   = 528,
    parameter int         ARR_PAGES   = 2,
    parameter int         BUSY_CYCLES = 1500,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_INFO    = 4'b1011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        si,
    output logic        so,
    input  logic [11:0] arr_rd_page,
    input  logic [9:0]  arr_rd_byte,
    output logic [7:0]  arr_rd_data
);
    localparam int PTR_W = $clog2(BUF_BYTES);

    logic             sel, si_s, sck_rise, sck_fall, cs_fall, cs_rise;
    logic             busy;
    logic             dec_wr_en, dec_wr_sel, dec_commit, dec_rewr, stat_mode;
    logic [PTR_W-1:0] dec_wr_addr;
    logic [7:0]       dec_wr_data;
    logic [11:0]      dec_page;
    logic [7:0]       status;

    assign status = {!busy, DEV_INFO, 3'b000};

    spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sel(sel), .si_s(si_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    cmd_decoder #(.BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .si_s(si_s), .sck_rise(sck_rise),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .busy(busy),
        .wr_en(dec_wr_en), .wr_sel(dec_wr_sel), .wr_addr(dec_wr_addr),
        .wr_data(dec_wr_data), .commit(dec_commit), .commit_rewr(dec_rewr),
        .commit_page(dec_page), .stat_mode(stat_mode)
    );

    status_tx u_stat (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cs_fall(cs_fall),
        .sck_fall(sck_fall), .stat_mode(stat_mode), .status(status), .so(so)
    );

    page_engine #(
        .BUF_BYTES(BUF_BYTES), .ARR_PAGES(ARR_PAGES),
        .BUSY_CYCLES(BUSY_CYCLES), .PTR_W(PTR_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .wr_en(dec_wr_en), .wr_sel(dec_wr_sel),
        .wr_addr(dec_wr_addr), .wr_data(dec_wr_data), .commit(dec_commit),
        .commit_rewr(dec_rewr), .commit_page(dec_page),
        .rd_page(arr_rd_page), .rd_byte(PTR_W'(arr_rd_byte)),
        .rd_data(arr_rd_data), .busy(busy)
    );
endmodule

// File: rtl/flash_buf_prog_chk.sv
// Module: flash_buf_prog_chk
// Cycle-level properties of the front end, bound into every flash_buf_prog.
module flash_buf_prog_chk #(
    parameter int BUF_BYTES   = 528,
    parameter int BUSY_CYCLES = 1500,
    parameter int PTR_W       = $clog2(BUF_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             so,
    input logic             sel,
    input logic             sck_fall,
    input logic             cs_rise,
    input logic             busy,
    input logic             dec_commit,
    input logic             dec_wr_en,
    input logic [PTR_W-1:0] dec_wr_addr
);
    logic [31:0] busy_len;

    // Count the length of the current busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 32'd1;
        else           busy_len <= '0;
    end

    assert_commit_on_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_commit |-> $past(cs_rise));

    assert_busy_after_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_commit && !busy) |=> busy);

    assert_min_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len >= 32'(BUSY_CYCLES)));

    assert_no_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dec_wr_en);

    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr_en |-> (32'(dec_wr_addr) < 32'(BUF_BYTES)));

    assert_so_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !so);

    assert_so_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sck_fall) |=> $stable(so));
endmodule

bind flash_buf_prog flash_buf_prog_chk #(
    .BUF_BYTES(BUF_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .so(so), .sel(sel), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .busy(busy), .dec_commit(dec_commit),
    .dec_wr_en(dec_wr_en), .dec_wr_addr(dec_wr_addr)
);

// File: tb/test_flash_buf_prog.sv
// Directed bench for flash_buf_prog: one task per scenario, each checking
// its own results against a byte-level model kept in the bench.
module test_flash_buf_prog;
    localparam int CLK_PERIOD = 10;
    localparam int SCK_HALF   = 8;       // system clocks per SCK half period
    localparam int NB         = 528;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so;
    logic [11:0] arr_rd_page = '0;
    logic [9:0]  arr_rd_byte = '0;
    logic [7:0]  arr_rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] mb [2][NB];
    logic [7:0] mp [2][NB];
    logic [7:0] dq [8];

    flash_buf_prog i_flash_buf_prog (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
        .arr_rd_page(arr_rd_page), .arr_rd_byte(arr_rd_byte),
        .arr_rd_data(arr_rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Compare one whole model page with the array inspection port.
    task automatic chk_page(input string tag, input int p);
        int bad = 0;
        logic [7:0] fa = 0, fe = 0;
        int fi = 0;
        for (int b = 0; b < NB; b++) begin
            arr_rd_page = 12'(p);
            arr_rd_byte = 10'(b);
            #1;
            if (arr_rd_data !== mp[p][b]) begin
                if (bad == 0) begin fa = arr_rd_data; fe = mp[p][b]; fi = b; end
                bad++;
            end
        end
        n_tests++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s page %0d byte %0d actual=%02h expected=%02h (%0d mismatches)",
                     tag, p, fi, fa, fe, bad);
        end
    endtask

    task automatic spi_begin();
        cs_n = 1'b0;
        wait_clks(SCK_HALF);
    endtask

    task automatic spi_end();
        wait_clks(SCK_HALF);
        cs_n = 1'b1;
        wait_clks(6);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_clks(SCK_HALF);
            rx[i] = so;
            sck = 1'b1;
            wait_clks(SCK_HALF);
            sck = 1'b0;
        end
    endtask

    // Program command: opcode, header, n data bytes from dq, then CS rise.
    task automatic send_prog(input logic [7:0] opc, input logic [11:0] pg,
                             input logic [9:0] ba, input int n, input bit apply);
        logic [23:0] hdr = {2'b00, pg, ba};
        logic [7:0]  rx;
        int sb = (opc == 8'h85) ? 1 : 0;
        int ptr = int'(ba) % NB;
        spi_begin();
        xfer(opc, rx);
        xfer(hdr[23:16], rx);
        xfer(hdr[15:8], rx);
        xfer(hdr[7:0], rx);
        for (int k = 0; k < n; k++) begin
            xfer(dq[k], rx);
            if (apply) begin
                mb[sb][ptr] = dq[k];
                ptr = (ptr + 1) % NB;
            end
        end
        spi_end();
        if (apply) for (int b = 0; b < NB; b++) mp[int'(pg) % 2][b] = mb[sb][b];
    endtask

    // Read status bytes in one select until ready or a limit.
    task automatic poll(output logic [7:0] first, output logic [7:0] last);
        logic [7:0] rx;
        spi_begin();
        xfer(8'h57, rx);
        first = 8'h00;
        last  = 8'h00;
        for (int n = 0; n < 40; n++) begin
            xfer(8'h00, rx);
            if (n == 0) first = rx;
            last = rx;
            if (rx == 8'hD8) break;
        end
        spi_end();
    endtask

    task automatic t_reset();
        logic [7:0] f, l;
        poll(f, l);
        chk8("R10 R6 status after reset", f, 8'hD8);
        chk_page("R10 array page 0 cleared", 0);
        chk_page("R10 array page 1 cleared", 1);
    endtask

    task automatic t_prog_buf1();
        logic [7:0] f, l;
        dq[0] = 8'hA1; dq[1] = 8'hA2; dq[2] = 8'hA3; dq[3] = 8'h5B;
        send_prog(8'h82, 12'h002, 10'd5, 3, 1'b1);
        poll(f, l);
        chk8("R7 busy seen after program start", f, 8'h58);
        chk8("R7 R6 ready after sequence", l, 8'hD8);
        chk_page("R1 R4 buffer 1 into page 0", 0);
        chk_page("R4 other page untouched", 1);
    endtask

    task automatic t_prog_buf2_mod();
        logic [7:0] f, l;
        dq[0] = 8'h10; dq[1] = 8'h20; dq[2] = 8'h30; dq[3] = 8'h40; dq[4] = 8'h50;
        send_prog(8'h85, 12'h001, 10'd600, 5, 1'b1);
        poll(f, l);
        chk8("R2 ready after buffer 2 program", l, 8'hD8);
        chk_page("R2 R1 address 600 lands at 72 in buffer 2", 1);
    endtask

    task automatic t_wrap();
        logic [7:0] f, l;
        dq[0] = 8'h11; dq[1] = 8'h22; dq[2] = 8'h33;
        send_prog(8'h82, 12'h000, 10'd526, 3, 1'b1);
        poll(f, l);
        chk_page("R3 pointer wraps 527 to 0", 0);
    endtask

    task automatic t_abort();
        logic [7:0] rx, f, l;
        spi_begin();
        xfer(8'h85, rx);
        xfer(8'h00, rx);
        xfer(8'h40, rx);
        spi_end();
        poll(f, l);
        chk8("R8 no busy after short header", f, 8'hD8);
        chk_page("R8 page 0 unchanged", 0);
        chk_page("R8 page 1 unchanged", 1);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] f, l;
        dq[0] = 8'h3C;
        send_prog(8'h82, 12'h003, 10'd0, 1, 1'b1);
        dq[0] = 8'h99; dq[1] = 8'h99;
        send_prog(8'h85, 12'h000, 10'd0, 2, 1'b0);
        poll(f, l);
        chk8("R9 status still busy after ignored command", f, 8'h58);
        chk_page("R9 first program completes", 1);
        chk_page("R9 ignored target page unchanged", 0);
        dq[0] = 8'h44;
        send_prog(8'h85, 12'h000, 10'd200, 1, 1'b1);
        poll(f, l);
        chk_page("R9 buffer 2 kept old bytes", 0);
    endtask

    task automatic t_rewrite();
        logic [7:0] rx, f, l;
        spi_begin();
        xfer(8'h59, rx);
        xfer(8'h00, rx);
        xfer(8'h07, rx);
        xfer(8'hFF, rx);
        spi_end();
        for (int b = 0; b < NB; b++) mb[1][b] = mp[1][b];
        poll(f, l);
        chk8("R5 rewrite runs busy", f, 8'h58);
        chk_page("R5 rewritten page unchanged", 1);
        dq[0] = 8'hEE;
        send_prog(8'h85, 12'h000, 10'd3, 1, 1'b1);
        poll(f, l);
        chk_page("R5 buffer 2 holds the rewritten page", 0);
    endtask

    task automatic t_status_repeat();
        logic [7:0] rx, a, b;
        spi_begin();
        xfer(8'h57, rx);
        xfer(8'h00, a);
        xfer(8'h00, b);
        spi_end();
        chk8("R6 first status byte", a, 8'hD8);
        chk8("R6 repeated status byte", b, 8'hD8);
        wait_clks(2);
        chk8("R6 SO low while deselected", {7'd0, so}, 8'h00);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            mb[0][b] = 8'h00; mb[1][b] = 8'h00;
            mp[0][b] = 8'h00; mp[1][b] = 8'h00;
        end
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        chk8("R10 SO low after reset", {7'd0, so}, 8'h00);
        t_reset();
        t_prog_buf1();
        t_prog_buf2_mod();
        t_wrap();
        t_abort();
        t_busy_ignore();
        t_rewrite();
        t_status_repeat();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule